// File: doc/BRIEF.md
# Streaming Vertical Line-Buffer Convolver

This block filters a raster-ordered pixel stream in the vertical direction. It applies a TAPS-tap FIR across consecutive lines. Pixels enter one per handshake, left to right and top to bottom. The block stores only TAPS-1 earlier lines, one entry per column per line. The live pixel acts as the newest tap, so a full extra line of storage is not needed. Each accepted pixel is weighted together with the TAPS-1 cached pixels above it in the same column. The signed full-width sum leaves on an output stream.

The first TAPS-1 lines of each frame only fill the line stores, and the block emits no results for them. From the first pixel of line TAPS-1 onwards, every input pixel yields exactly one output, until the frame's last pixel. The counters then wrap and the next frame starts its own warm-up.

Both streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. While the output register holds a result that is not taken, that result and its valid stay frozen. Warm-up pixels do not need the output, so they keep flowing even while the output is stalled. A pixel that would produce a result waits until the output register is free or is being emptied in the same cycle. The coefficients are a static configuration input and must not change inside a frame.

Top module: `column_fir_stream`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Pixels accepted in rows 0 to TAPS-2 of a frame produce no output.
- R3: For a pixel accepted at row r ≥ TAPS-1 and column c, exactly one output is produced. Its value is the sum over i = 0..TAPS-1 of coef[i] × pixel(r-TAPS+1+i, c). Tap 0 is the oldest line, and tap TAPS-1 is the live pixel.
- R4: Outputs leave in acceptance order, with exactly (HEIGHT-TAPS+1)×WIDTH outputs per frame.
- R5: While out_valid is 1 and out_ready is 0, on the next cycle out_valid stays 1 and out_data is unchanged.
- R6: While the current position is in a warm-up row, in_ready is 1 even when a stalled result is held on the output.
- R7: The column counter runs 0..WIDTH-1 and the row counter runs 0..HEIGHT-1. After the last pixel of a frame both return to 0, and the next frame repeats its warm-up.
- R8: Pixels are unsigned PIX_W-bit values. coef[i] is a two's-complement COEF_W-bit field at coef_flat[i*COEF_W +: COEF_W]. out_data is a two's-complement sum PIX_W+COEF_W+1+clog2(TAPS) bits wide that cannot overflow, even at extreme values.
- R9: A reset in the middle of a frame discards the partial frame. The next pixel is treated as row 0, column 0.
- R10: With in_valid and out_ready held high, one pixel is accepted per clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_flat | input | TAPS*COEF_W | Static coefficients; field i weights tap i |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block takes the input pixel this cycle |
| in_data | input | PIX_W | Unsigned input pixel |
| out_valid | output | 1 | Output result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | ACC_W | Signed filtered result |

## Verification
Two things can happen in the same cycle: the output stage can hold a stalled result, and a warm-up pixel of the next frame can be accepted. The bench creates this case by dropping out_ready just before the last pixel of a frame and then feeding the first TAPS-1 lines of the next frame. It requires in_ready to stay high for every one of those pixels, and the held result to stay unchanged. Once out_ready returns, the scoreboard must see that held result followed by the next frame's results in order, and the per-frame output count must be exact.

// File: rtl/vfir_pkg.sv
package vfir_pkg;
  // Bits needed for a signed sum of taps products (unsigned pixel, signed weight)
  function automatic int acc_width(int pix_w, int coef_w, int taps);
    return pix_w + coef_w + 1 + $clog2(taps);
  endfunction

  // Index width that never collapses to zero
  function automatic int idx_width(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vfir_raster.sv
module vfir_raster #(
  parameter int WIDTH  = 64,
  parameter int HEIGHT = 48,
  parameter int TAPS   = 5,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             warm,
  output logic             last
);
  logic col_end;
  assign col_end = (col == COL_W'(WIDTH - 1));
  assign last    = col_end && (row == ROW_W'(HEIGHT - 1));
  assign warm    = (row < ROW_W'(TAPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (col_end) begin
        col <= '0;
        row <= last ? '0 : row + ROW_W'(1);
      end else begin
        col <= col + COL_W'(1);
      end
    end
  end

  // R7
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && last) |=> (row == '0 && col == '0));

  // R7
  col_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !col_end) |=> (col == $past(col) + COL_W'(1) && row == $past(row)));
endmodule

// File: rtl/vfir_linebuf.sv
module vfir_linebuf #(
  parameter int PIX_W = 8,
  parameter int WIDTH = 64,
  parameter int TAPS  = 5,
  parameter int COL_W = 6
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [COL_W-1:0]      col,
  input  logic [PIX_W-1:0]      din,
  output logic [TAPS*PIX_W-1:0] win_flat
);
  localparam int LINES = TAPS - 1;

  // chain[t] is the window value for tap t; the live pixel closes the chain
  logic [PIX_W-1:0] chain [TAPS];
  assign chain[LINES] = din;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [PIX_W-1:0] mem [WIDTH];
    assign chain[g] = mem[col];
    // read-before-write: the old entry feeds tap g while tap g+1 replaces it
    always_ff @(posedge clk) begin
      if (we) mem[col] <= chain[g + 1];
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_win
    assign win_flat[t*PIX_W +: PIX_W] = chain[t];
  end
endmodule

// File: rtl/vfir_mac.sv
module vfir_mac #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 5,
  parameter int ACC_W  = 20
) (
  input  logic [TAPS*PIX_W-1:0]  win_flat,
  input  logic [TAPS*COEF_W-1:0] coef_flat,
  output logic [ACC_W-1:0]       sum
);
  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic signed [PIX_W:0]    pix_s;
    logic signed [COEF_W-1:0] coef_s;
    assign pix_s   = $signed({1'b0, win_flat[t*PIX_W +: PIX_W]});
    assign coef_s  = $signed(coef_flat[t*COEF_W +: COEF_W]);
    assign prod[t] = PROD_W'(pix_s * coef_s);
  end

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++) begin
      sum = sum + {{EXT_W{prod[t][PROD_W-1]}}, prod[t]};
    end
  end
endmodule

// File: rtl/column_fir_stream.sv
module column_fir_stream import vfir_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 5,
  parameter int WIDTH  = 64,
  parameter int HEIGHT = 48,
  parameter int ACC_W  = acc_width(PIX_W, COEF_W, TAPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TAPS*COEF_W-1:0] coef_flat,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ACC_W-1:0]       out_data
);
  localparam int COL_W = idx_width(WIDTH);
  localparam int ROW_W = idx_width(HEIGHT);

  logic [COL_W-1:0]      col;
  logic [ROW_W-1:0]      row;
  logic                  warm, last, accept, out_free;
  logic [TAPS*PIX_W-1:0] win_flat;
  logic [ACC_W-1:0]      sum;

  assign out_free = !out_valid || out_ready;
  assign in_ready = out_free || warm;
  assign accept   = in_valid && in_ready;

  vfir_raster #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .TAPS(TAPS),
                .COL_W(COL_W), .ROW_W(ROW_W)) u_raster (
    .clk(clk), .rst(rst), .step(accept),
    .col(col), .row(row), .warm(warm), .last(last)
  );

  vfir_linebuf #(.PIX_W(PIX_W), .WIDTH(WIDTH), .TAPS(TAPS), .COL_W(COL_W)) u_lines (
    .clk(clk), .we(accept), .col(col), .din(in_data), .win_flat(win_flat)
  );

  vfir_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_mac (
    .win_flat(win_flat), .coef_flat(coef_flat), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept && !warm) begin
      out_valid <= 1'b1;
      out_data  <= sum;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  warm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && warm && out_ready) |=> !out_valid);

  // R3
  result_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !warm) |=> out_valid);
endmodule

// File: tb/sim_column_fir_stream.sv
`timescale 1ns/1ps
module sim_column_fir_stream;
  localparam int PW = 8, CW = 8, K = 3, W = 8, H = 6;
  localparam int AW = PW + CW + 1 + $clog2(K);
  localparam int PER_FRAME = (H - K + 1) * W;

  logic clk = 1'b0, rst = 1'b1;
  logic [K*CW-1:0] coef_flat = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [PW-1:0] in_data = '0;
  logic [AW-1:0] out_data;

  column_fir_stream #(.PIX_W(PW), .COEF_W(CW), .TAPS(K), .WIDTH(W), .HEIGHT(H)) u0 (
    .clk(clk), .rst(rst), .coef_flat(coef_flat), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, out_cnt = 0;
  int cf [K];
  int img [H][W];
  int mr = 0, mc = 0;
  int expq [$];
  int bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic hold_pend = 1'b0;
  logic [AW-1:0] held;
  int first_acc, last_acc;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000) begin
        chk(1'b0, "WATCHDOG", "run length", cyc, 100000);
        summary();
      end
    end
  end

  // downstream ready pattern
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[3] | lfsr[7];
      default: out_ready = 1'b0;
    endcase
  end

  // monitor: pops the scoreboard, also watches the stall rule (R5)
  always @(negedge clk) begin
    if (rst) begin
      hold_pend = 1'b0;
    end else begin
      if (hold_pend) begin
        chk(out_valid == 1'b1, "R5", "valid held under stall", int'(out_valid), 1);
        chk(out_data == held, "R5", "data held under stall", $signed(out_data), $signed(held));
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R2", "output with nothing expected", $signed(out_data), 0);
        end else begin
          int e;
          e = expq.pop_front();
          chk($signed(out_data) == e, "R3", "result value", $signed(out_data), e);
          out_cnt++;
        end
      end
      hold_pend = out_valid && !out_ready;
      held = out_data;
    end
  end

  task automatic set_coef(int a, int b, int c);
    cf[0] = a; cf[1] = b; cf[2] = c;
    coef_flat = {CW'(c), CW'(b), CW'(a)};
  endtask

  // driver: offers one pixel, waits for acceptance, feeds the model
  task automatic send(int p);
    in_valid = 1'b1;
    in_data  = PW'(p);
    do @(negedge clk); while (!in_ready);
    if (mr == 0 && mc == 0) first_acc = cyc;
    last_acc = cyc;
    img[mr][mc] = p;
    if (mr >= K - 1) begin
      int s;
      s = 0;
      for (int i = 0; i < K; i++) s += cf[i] * img[mr - K + 1 + i][mc];
      expq.push_back(s);
    end
    mc++;
    if (mc == W) begin
      mc = 0;
      mr = (mr == H - 1) ? 0 : mr + 1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic int pix(int kind, int r, int c);
    case (kind)
      0: return (r * 37 + c * 11) & 255;
      1: return (r * 97 + c * 53 + r * c * 7 + 13) & 255;
      default: return 255;
    endcase
  endfunction

  task automatic drain();
    bp_mode = 0;
    while (expq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic check_count(int base, int frames, string tag);
    chk(out_cnt - base == frames * PER_FRAME, "R4", tag, out_cnt - base, frames * PER_FRAME);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    // frame A: ramp, free-flowing output; R10 throughput, R3 values
    set_coef(1, -2, 3);
    base = out_cnt;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) send(pix(0, r, c));
    chk(last_acc - first_acc == W * H - 1, "R10", "cycles for one frame",
        last_acc - first_acc, W * H - 1);
    drain();
    check_count(base, 1, "outputs in frame A");

    // frame B: irregular pixels, random back-pressure, pause after warm-up (R2)
    set_coef(-5, 7, 2);
    base = out_cnt;
    bp_mode = 1;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (r == K - 1 && c == 0) begin
          repeat (4) @(negedge clk);
          chk(out_valid == 1'b0, "R2", "quiet after warm-up rows", int'(out_valid), 0);
          chk(expq.size() == 0, "R2", "nothing expected yet", expq.size(), 0);
          @(posedge clk); #1;
        end
        send(pix(1, r, c));
      end
    drain();
    check_count(base, 1, "outputs in frame B (wrapped counters R7)");

    // frame C: extreme values, R8
    set_coef(-128, -128, -128);
    base = out_cnt;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) send(pix(2, r, c));
    drain();
    check_count(base, 1, "outputs in frame C");
    chk(K * 255 * -128 == -97920, "R8", "extreme sum reference", K * 255 * -128, -97920);

    // frames D and E: stalled last result while next warm-up flows (R6)
    set_coef(3, 1, -4);
    base = out_cnt;
    for (int i = 0; i < W * H - 1; i++) send(pix(1, i / W, i % W));
    drain();
    bp_mode = 2;
    @(posedge clk); #1;
    send(pix(1, H - 1, W - 1));
    for (int i = 0; i < W * (K - 1); i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R6", "warm-up pixel accepted under stall", int'(in_ready), 1);
      @(posedge clk); #1;
      send(pix(0, i / W, i % W));
    end
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "held result still present", int'(out_valid), 1);
    chk(in_ready == 1'b0, "R6", "result pixel waits for output", int'(in_ready), 0);
    @(posedge clk); #1;
    bp_mode = 0;
    for (int i = W * (K - 1); i < W * H; i++) send(pix(0, i / W, i % W));
    drain();
    check_count(base, 2, "outputs in frames D and E");

    // R9: reset in the middle of a frame
    for (int i = 0; i < W * K + 3; i++) send(pix(0, i / W, i % W));
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    expq.delete();
    mr = 0; mc = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after mid-frame reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after mid-frame reset", int'(in_ready), 1);
    @(posedge clk); #1;
    base = out_cnt;
    set_coef(2, 2, 2);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) send(pix(1, r + 2, c));
    drain();
    check_count(base, 1, "outputs after reset restart (R9)");
    chk(expq.size() == 0, "R4", "scoreboard empty at end", expq.size(), 0);
    summary();
  end
endmodule